// File: doc/BRIEF.md
# Bitmap Packet-Identifier Filter

This block sits behind a transport-stream sync detector and decides, packet by packet, whether a packet is forwarded or thrown away. It gathers the leading eight bytes of each packet into one big-endian 64-bit word. It cuts a programmable bit slice out of that word to form the packet identifier. It then looks that identifier up in a one-bit-per-identifier table held in local registers.

Every byte of a packet is parked in a one-packet store until the verdict is known at the last byte. A kept packet is then replayed whole and without gaps. A rejected packet leaves nothing on the output. Software fills the table through a word-wide write port. Writes that arrive while a packet is being received are held back and land when that packet closes, so a table update never changes the verdict of a packet already in flight. With filtering switched off, every packet goes through.

Top module: `pid_bitmap_filter`

## Requirements
- R1: After reset the output is idle (`out_valid` low) and every table bit is zero, so with filtering enabled no packet is forwarded.
- R2: Header byte k of a packet (k = 0..7, byte 0 carrying `in_sop`) sits at bits [63-8k : 56-8k] of the 64-bit header word. Header bytes a shorter packet never delivers read as zero.
- R3: The identifier is bits [cfg_offset+n-1 : cfg_offset] of the header word, where n = min(cfg_numbits, ID_W). Bits above 63 read as zero, and n = 0 gives identifier 0.
- R4: Identifier i is bit (i mod WORD_W) of table word (i / WORD_W). A write on `tbl_we` replaces the whole addressed word.
- R5: When the identifier's bit is 1 the packet leaves unchanged, with `out_sop` on its first byte and `out_eop` on its last. When the bit is 0 no byte of it appears.
- R6: With `cfg_enable` low every packet is forwarded whatever the table holds.
- R7: A table write in a cycle where a packet is open and its last byte is not being accepted is deferred. It does not change the table before that packet's last byte, and it takes effect for the next packet. Up to WQ_DEPTH such writes are held per packet.
- R8: The first byte of a kept packet appears on the output in the cycle after the one in which its `in_eop` byte is accepted. Its remaining bytes follow on consecutive cycles.
- R9: An `in_sop` byte that arrives while a packet is still open throws away the unfinished packet and starts a new one.
- R10: Bytes with `in_valid` high that arrive while no packet is open and without `in_sop` are ignored.
- R11: Packets of up to PKT_MAX bytes may arrive back to back with no idle cycles, and no kept byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| cfg_enable | input | 1 | Filtering on (1) or bypass (0) |
| cfg_offset | input | 6 | Low bit of the identifier slice in the header word |
| cfg_numbits | input | $clog2(ID_W+1) | Identifier slice width |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | ID_W-$clog2(WORD_W) | Table word index |
| tbl_wdata | input | WORD_W | Table word value |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output packet byte |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_eop | output | 1 | Last byte of a forwarded packet |

## Verification
The bench loads an arithmetic pattern into the table and sweeps every identifier of a small configuration back to back. This separates the table bit order from the word addressing. A second sweep changes the slice offset and width on every packet, including widths past the limit and slices that run off the top of the word, with headers that differ in every byte. This catches a reversed byte order or a wrong shift. Short packets, a stray-byte burst, an abandoned partial packet, and a write issued mid-packet in both directions (set and clear) each check one corner. Full-length packets that alternate between kept and dropped stress the shared store.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
   typedef struct packed {
      logic       sop;
      logic       eop;
      logic [7:0] data;
   } pidf_beat_t;
endpackage

// File: rtl/pidf_hdr_extract.sv
module pidf_hdr_extract #(
   parameter int ID_W = 13,
   parameter int NB_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc,
   input  logic            first,
   input  logic [7:0]      data,
   input  logic [5:0]      cfg_offset,
   input  logic [NB_W-1:0] cfg_numbits,
   output logic [ID_W-1:0] id_now
);
   localparam int HDR_BYTES = 8;

   logic [63:0]     hdr_q;
   logic [63:0]     hdr_now;
   logic [3:0]      idx_q;
   logic [3:0]      pos;
   logic [NB_W-1:0] nb_c;
   logic [ID_W-1:0] mask;

   generate
      if (ID_W > 64) begin : g_bad_id
         $error("pidf_hdr_extract: ID_W must not exceed 64");
      end
   endgenerate

   always_comb begin
      pos     = first ? 4'd0 : idx_q;
      hdr_now = first ? 64'd0 : hdr_q;
      if (pos < 4'(HDR_BYTES))
         hdr_now[(7 - int'(pos)) * 8 +: 8] = data;
      nb_c   = (cfg_numbits > NB_W'(ID_W)) ? NB_W'(ID_W) : cfg_numbits;
      mask   = ~({ID_W{1'b1}} << nb_c);
      id_now = ID_W'(hdr_now >> cfg_offset) & mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_q <= '0;
         idx_q <= '0;
      end else if (acc) begin
         hdr_q <= hdr_now;
         idx_q <= (pos < 4'(HDR_BYTES)) ? pos + 4'd1 : pos;
      end
   end
endmodule

// File: rtl/pidf_bitmap.sv
module pidf_bitmap #(
   parameter int ID_W     = 13,
   parameter int WORD_W   = 32,
   parameter int WQ_DEPTH = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ID_W-$clog2(WORD_W)-1:0]       wr_addr,
   input  logic [WORD_W-1:0]                    wr_data,
   input  logic                                 busy,
   input  logic                                 close,
   input  logic [ID_W-1:0]                      look_id,
   output logic                                 hit
);
   localparam int BIT_W     = $clog2(WORD_W);
   localparam int TA_W      = ID_W - BIT_W;
   localparam int TBL_WORDS = 1 << TA_W;
   localparam int QC_W      = $clog2(WQ_DEPTH + 1);

   logic [TA_W-1:0]                  q_addr [WQ_DEPTH];
   logic [WORD_W-1:0]                q_data [WQ_DEPTH];
   logic [QC_W-1:0]                  q_cnt;
   logic                             defer;
   logic                             direct;
   logic [TBL_WORDS-1:0][WORD_W-1:0] tbl_flat;

   assign defer  = wr_en & busy;
   assign direct = wr_en & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_cnt <= '0;
      else if (close)
         q_cnt <= '0;
      else if (defer && q_cnt < QC_W'(WQ_DEPTH))
         q_cnt <= q_cnt + 1'b1;
   end

   generate
      for (genvar s = 0; s < WQ_DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (defer && !close && q_cnt == QC_W'(s)) begin
               q_addr[s] <= wr_addr;
               q_data[s] <= wr_data;
            end
         end
      end

      for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
         logic [WORD_W-1:0]   word_q;
         logic [WQ_DEPTH-1:0] flush_hit;
         always_comb begin
            for (int s = 0; s < WQ_DEPTH; s++)
               flush_hit[s] = close && (q_cnt > QC_W'(s)) && (q_addr[s] == TA_W'(w));
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q <= '0;
            end else begin
               for (int s = 0; s < WQ_DEPTH; s++)
                  if (flush_hit[s]) word_q <= q_data[s];
               if (direct && wr_addr == TA_W'(w)) word_q <= wr_data;
            end
         end
         assign tbl_flat[w] = word_q;
      end
   endgenerate

   assign hit = tbl_flat[look_id[ID_W-1:BIT_W]][look_id[BIT_W-1:0]];

   AST_MIDPKT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      defer |=> $stable(tbl_flat)); // R7
   AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      defer |-> q_cnt < QC_W'(WQ_DEPTH)); // R7
endmodule

// File: rtl/pidf_pkt_buffer.sv
module pidf_pkt_buffer
   import pidf_pkg::*;
#(
   parameter int DEPTH = 188
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc,
   input  logic       first,
   input  logic       last,
   input  logic       keep,
   input  logic [7:0] data,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_sop,
   output logic       out_eop
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LEN_W = $clog2(DEPTH + 1);

   pidf_beat_t       mem [DEPTH];
   pidf_beat_t       out_q;
   logic [PTR_W-1:0] wr_q, cmt_q, rd_q, slot;
   logic [LEN_W-1:0] len_q, len_now, avail_q;
   logic             rd_fire, commit;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign slot    = first ? cmt_q : wr_q;
   assign len_now = first ? LEN_W'(1) : len_q + 1'b1;
   assign rd_fire = (avail_q != '0);
   assign commit  = acc & last & keep;

   always_ff @(posedge clk) begin
      if (acc) mem[slot] <= '{sop: first, eop: last, data: data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         cmt_q   <= '0;
         len_q   <= '0;
         avail_q <= '0;
      end else begin
         if (acc) begin
            len_q <= len_now;
            if (last && keep) begin
               wr_q  <= nxt(slot);
               cmt_q <= nxt(slot);
            end else if (last) begin
               wr_q  <= cmt_q;
            end else begin
               wr_q  <= nxt(slot);
            end
         end
         avail_q <= avail_q - (rd_fire ? LEN_W'(1) : LEN_W'(0))
                            + (commit ? len_now : LEN_W'(0));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q      <= '0;
         out_valid <= 1'b0;
         out_q     <= '0;
      end else begin
         out_valid <= rd_fire;
         if (rd_fire) begin
            out_q <= mem[rd_q];
            rd_q  <= nxt(rd_q);
         end
      end
   end

   assign out_data = out_q.data;
   assign out_sop  = out_q.sop & out_valid;
   assign out_eop  = out_q.eop & out_valid;

   AST_NO_LONG_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !first) |-> len_q < LEN_W'(DEPTH)); // R11
   AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      avail_q <= LEN_W'(DEPTH)); // R11
   AST_OUT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |=> (out_valid && !out_sop)); // R8
   AST_OUT_STARTS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_sop); // R5
endmodule

// File: rtl/pid_bitmap_filter.sv
module pid_bitmap_filter #(
   parameter int ID_W     = 13,
   parameter int WORD_W   = 32,
   parameter int PKT_MAX  = 188,
   parameter int WQ_DEPTH = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [7:0]                        in_data,
   input  logic                              in_sop,
   input  logic                              in_eop,
   input  logic                              cfg_enable,
   input  logic [5:0]                        cfg_offset,
   input  logic [$clog2(ID_W+1)-1:0]         cfg_numbits,
   input  logic                              tbl_we,
   input  logic [ID_W-$clog2(WORD_W)-1:0]    tbl_addr,
   input  logic [WORD_W-1:0]                 tbl_wdata,
   output logic                              out_valid,
   output logic [7:0]                        out_data,
   output logic                              out_sop,
   output logic                              out_eop
);
   localparam int NB_W  = $clog2(ID_W + 1);
   localparam int BIT_W = $clog2(WORD_W);

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("pid_bitmap_filter: WORD_W must be a power of two >= 2");
      end
      if (ID_W <= BIT_W || ID_W > 64) begin : g_bad_idw
         $error("pid_bitmap_filter: ID_W must exceed log2(WORD_W) and be <= 64");
      end
      if (PKT_MAX < 2) begin : g_bad_pkt
         $error("pid_bitmap_filter: PKT_MAX must be at least 2");
      end
      if (WQ_DEPTH < 1) begin : g_bad_wq
         $error("pid_bitmap_filter: WQ_DEPTH must be at least 1");
      end
   endgenerate

   logic            pkt_open_q;
   logic            first, acc, last, busy, keep, hit;
   logic [ID_W-1:0] id_now;

   assign first = in_valid & in_sop;
   assign acc   = in_valid & (in_sop | pkt_open_q);
   assign last  = acc & in_eop;
   assign busy  = (pkt_open_q | first) & ~last;
   assign keep  = ~cfg_enable | hit;

   always_ff @(posedge clk) begin
      if (!rst_n)   pkt_open_q <= 1'b0;
      else if (acc) pkt_open_q <= ~in_eop;
   end

   pidf_hdr_extract #(.ID_W(ID_W), .NB_W(NB_W)) i_hdr (
      .clk(clk), .rst_n(rst_n), .acc(acc), .first(first), .data(in_data),
      .cfg_offset(cfg_offset), .cfg_numbits(cfg_numbits), .id_now(id_now));

   pidf_bitmap #(.ID_W(ID_W), .WORD_W(WORD_W), .WQ_DEPTH(WQ_DEPTH)) i_bitmap (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
      .wr_data(tbl_wdata), .busy(busy), .close(last), .look_id(id_now),
      .hit(hit));

   pidf_pkt_buffer #(.DEPTH(PKT_MAX)) i_buf (
      .clk(clk), .rst_n(rst_n), .acc(acc), .first(first), .last(last),
      .keep(keep), .data(in_data), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop));

   AST_STRAY_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sop && !pkt_open_q) |=> !pkt_open_q); // R10
endmodule

// File: tb/test_pid_bitmap_filter.sv
`timescale 1ns/1ps
module test_pid_bitmap_filter;
   localparam int ID_W = 8, WORD_W = 8, PKT_MAX = 24, WQ_DEPTH = 2;
   localparam int NB_W = 4, TA_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 0, in_sop = 0, in_eop = 0;
   logic [7:0] in_data = '0;
   logic cfg_enable = 1;
   logic [5:0] cfg_offset = 6'd40;
   logic [NB_W-1:0] cfg_numbits = 4'd8;
   logic tbl_we = 0;
   logic [TA_W-1:0] tbl_addr = '0;
   logic [WORD_W-1:0] tbl_wdata = '0;
   logic out_valid, out_sop, out_eop;
   logic [7:0] out_data;

   int n_cmp = 0, n_mis = 0, seq = 0;
   bit running = 0;
   string cur_req = "R1";
   logic [255:0] model = '0;
   logic [9:0] exp_q[$];

   always #10 clk = ~clk;

   pid_bitmap_filter #(.ID_W(ID_W), .WORD_W(WORD_W), .PKT_MAX(PKT_MAX),
                       .WQ_DEPTH(WQ_DEPTH)) i_pid_bitmap_filter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .cfg_enable(cfg_enable),
      .cfg_offset(cfg_offset), .cfg_numbits(cfg_numbits), .tbl_we(tbl_we),
      .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_mis++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running && out_valid) begin
         if (exp_q.size() == 0)
            check(0, {cur_req, " unexpected output byte"}, {out_sop, out_eop, out_data}, 0);
         else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            check({out_sop, out_eop, out_data} == e, cur_req, {out_sop, out_eop, out_data}, e);
         end
      end
   end

   // identifier per R2/R3: absent header bytes are zero, width clamped to ID_W
   function automatic int exp_id(input logic [63:0] h, input int len, input int off, input int nb);
      logic [63:0] w;
      int n;
      w = h;
      for (int k = len; k < 8; k++) w[63 - 8*k -: 8] = 8'h00;
      n = (nb > ID_W) ? ID_W : nb;
      return int'((w >> off) & ((64'd1 << n) - 64'd1));
   endfunction

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0; tbl_we = 0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic write_word(input int a, input logic [7:0] d);
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0;
      tbl_we = 1; tbl_addr = TA_W'(a); tbl_wdata = d;
      model[a*8 +: 8] = d;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic send_pkt(input logic [63:0] h, input int len, input bit en,
                           input int off, input int nb, input bit mid_we,
                           input int mid_at, input int ma, input logic [7:0] md,
                           input bit no_eop);
      logic [7:0] b[PKT_MAX];
      bit pass;
      int id;
      id = exp_id(h, len, off, nb);
      pass = !en || model[id];
      for (int k = 0; k < len; k++)
         b[k] = (k < 8) ? h[63 - 8*k -: 8] : 8'((k * 13 + seq) & 255);
      seq++;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (k == 0) begin
            cfg_enable = en; cfg_offset = 6'(off); cfg_numbits = NB_W'(nb);
         end
         in_valid = 1; in_data = b[k]; in_sop = (k == 0);
         in_eop = (k == len - 1) && !no_eop;
         tbl_we = mid_we && (k == mid_at);
         tbl_addr = TA_W'(ma); tbl_wdata = md;
         if (k == len - 1 && !no_eop && pass)
            for (int j = 0; j < len; j++)
               exp_q.push_back({j == 0, j == len - 1, b[j]});
      end
      if (mid_we) model[ma*8 +: 8] = md;
   endtask

   task automatic drain(input string req);
      idle(1);
      repeat (PKT_MAX * 3 + 4) @(negedge clk);
      check(exp_q.size() == 0, {req, " pending expected bytes"}, exp_q.size(), 0);
   endtask

   initial begin
      #(200000 * 20);
      n_mis++;
      $display("FAIL watchdog expired in %s actual=running expected=done", cur_req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 0, "R1 idle in reset", out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 0, "R1 idle after reset", out_valid, 0);
      running = 1;

      // R1: cleared table drops everything when enabled
      cur_req = "R1";
      for (int i = 0; i < 8; i++)
         send_pkt({8'h47, 8'h10, 8'(i * 31), 40'h0123456789}, 10, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R1");

      // R4/R5/R11: patterned table, all identifiers back to back
      cur_req = "R4 R5 R11 sweep";
      for (int a = 0; a < 32; a++) write_word(a, 8'((a * 29 + 7) & 255));
      for (int i = 0; i < 256; i++)
         send_pkt({8'h47, 8'(i), 8'(i), 40'hA1B2C3D4E5}, 10, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R4 R5");
      // R4: whole-word replacement
      cur_req = "R4 rewrite";
      write_word(3, 8'hFF);
      write_word(3, 8'h01);
      for (int i = 24; i < 32; i++)
         send_pkt({8'h47, 8'h00, 8'(i), 40'h0}, 9, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R4");

      // R2/R3: slice offset and width sweep
      cur_req = "R2 R3 slice";
      for (int i = 0; i < 96; i++)
         send_pkt(64'h0123456789ABCDEF * 64'(i + 3) ^ 64'(i * 977), 12, 1,
                  (i * 7) % 64, i % 12, 0, 0, 0, 0, 0);
      drain("R3");

      // R2: short packets with missing header bytes
      cur_req = "R2 short";
      for (int i = 0; i < 24; i++)
         send_pkt(64'hFEDCBA9876543210 ^ 64'(i * 12345), 2 + (i % 6), 1,
                  (i * 11) % 64, 8, 0, 0, 0, 0, 0);
      drain("R2");

      // R6: bypass forwards all even with an empty table
      cur_req = "R6 bypass";
      for (int a = 0; a < 32; a++) write_word(a, 8'h00);
      for (int i = 0; i < 16; i++)
         send_pkt({8'h47, 8'h00, 8'(i * 16), 40'h55}, 9, 0, 40, 8, 0, 0, 0, 0, 0);
      drain("R6");

      // R7: mid-packet set then mid-packet clear
      cur_req = "R7 deferred set";
      send_pkt({8'h47, 8'h00, 8'd5, 40'h0}, 12, 1, 40, 8, 1, 3, 0, 8'h20, 0);
      send_pkt({8'h47, 8'h00, 8'd5, 40'h0}, 12, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R7");
      cur_req = "R7 deferred clear";
      send_pkt({8'h47, 8'h00, 8'd5, 40'h0}, 12, 1, 40, 8, 1, 0, 0, 8'h00, 0);
      send_pkt({8'h47, 8'h00, 8'd5, 40'h0}, 12, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R7");

      // R9: abandoned partial packet
      cur_req = "R9 restart";
      write_word(1, 8'hFF);
      send_pkt({8'h47, 8'h00, 8'd9, 40'h0}, 6, 1, 40, 8, 0, 0, 0, 0, 1);
      send_pkt({8'h47, 8'h00, 8'd10, 40'h0}, 11, 1, 40, 8, 0, 0, 0, 0, 0);
      drain("R9");

      // R10: stray bytes outside any packet
      cur_req = "R10 stray";
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         in_valid = 1; in_sop = 0; in_eop = (k == 5); in_data = 8'(k);
      end
      drain("R10");

      // R8: first byte one cycle after eop acceptance
      cur_req = "R8 latency";
      send_pkt({8'h47, 8'h00, 8'd12, 40'h0}, 4, 1, 40, 8, 0, 0, 0, 0, 0);
      @(negedge clk);
      in_valid = 0; in_eop = 0; in_sop = 0;
      check(out_valid == 0, "R8 not before", out_valid, 0);
      @(negedge clk);
      check(out_valid == 1 && out_sop == 1, "R8 first byte", {out_valid, out_sop}, 3);
      drain("R8");

      // R11: full-length packets back to back, kept and dropped mixed
      cur_req = "R11 full length";
      for (int i = 0; i < 12; i++)
         send_pkt({8'h47, 8'h00, 8'((i % 2) ? 8 + i : 64 + i), 40'h0}, PKT_MAX, 1,
                  40, 8, 0, 0, 0, 0, 0);
      drain("R11");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule